// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst on a synchronous burst memory. At a rising clock edge, either of two active-low address strobes captures an external word address. One strobe is meant for a processor and the other for a memory controller. After that, each edge at which the active-low advance input is low moves a small burst counter on by one. The low address bits are formed from the captured start value and that counter. The upper bits stay as captured.

An ordering input selects how the low bits walk through the burst. In linear order they count up from the start value and wrap within the aligned group of four. In interleaved order they are the start value XORed with the beat number. In both orders the fifth beat returns to the start address. The sequence never carries into the upper bits. The block has no data path. All inputs are plain level-sensitive control and address pins, so there is no handshake and no back-pressure.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after the first rising edge it sees, `addr_out` is all zeros.
- R2: When `proc_as_n` is low at a rising edge, `addr_in` is captured, and after that edge `addr_out` equals `addr_in` in either order.
- R3: When `ctrl_as_n` is low at a rising edge, `addr_in` is captured exactly as for R2.
- R4: When a strobe and `adv_n` are both low at the same edge, the strobe wins: the new address is loaded and the burst count restarts at 0.
- R5: When both strobes are high and `adv_n` is low at an edge, the beat number rises by one, modulo 4.
- R6: With `order_xor` = 0 (linear), `addr_out[1:0]` = (start[1:0] + beat) mod 4.
- R7: With `order_xor` = 1 (interleaved), `addr_out[1:0]` = start[1:0] XOR beat.
- R8: `addr_out[ADDR_W-1:2]` changes only at a strobe edge. After four advances, `addr_out` is back at the start address.
- R9: When both strobes and `adv_n` are high at an edge, `addr_out` keeps its value.
- R10: `order_xor` acts on `addr_out` with no clock latency. Changing it between edges re-maps the current beat without moving the beat number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_as_n | input | 1 | Processor address strobe, active low |
| ctrl_as_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | Start word address |
| addr_out | output | ADDR_W | Current burst word address |

## Verification
Strobe, advance and hold results (R2 to R9) are registered. They appear on `addr_out` one rising edge after the inputs are sampled. The order select (R10) acts within the same cycle, because it only steers logic after the registers. The bench drives inputs on the falling edge and compares against its model shortly after each rising edge. For R10 it compares again a moment after changing `order_xor`, with no clock edge in between.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } act_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_seq_pkg::*;
(
  input  logic proc_as_n,
  input  logic ctrl_as_n,
  input  logic adv_n,
  output act_e act
);
  // strobes take priority over advance
  always_comb begin
    if (!proc_as_n || !ctrl_as_n) act = ACT_LOAD;
    else if (!adv_n)              act = ACT_STEP;
    else                          act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)               base <= '0;
    else if (act == ACT_LOAD) base <= addr_in;
  end
endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act,
  output logic [CNT_W-1:0] beat
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) beat <= '0;
    else begin
      case (act)
        ACT_LOAD: beat <= '0;
        ACT_STEP: beat <= beat + ONE;  // wraps modulo 2**CNT_W
        default:  beat <= beat;
      endcase
    end
  end
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_lo,
  input  logic [CNT_W-1:0] beat,
  input  logic             order_xor,
  output logic [CNT_W-1:0] lo
);
  logic [CNT_W-1:0] lin_lo;
  logic [CNT_W-1:0] xor_lo;
  order_e           ord;

  assign lin_lo = start_lo + beat;
  assign xor_lo = start_lo ^ beat;
  assign ord    = order_e'(order_xor);

  always_comb begin
    case (ord)
      ORD_XOR: lo = xor_lo;
      default: lo = lin_lo;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_as_n,
  input  logic              ctrl_as_n,
  input  logic              adv_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - CNT_W;

  act_e              act;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  beat;
  logic [CNT_W-1:0]  lo;

  burst_ctrl u_ctrl (
    .proc_as_n (proc_as_n),
    .ctrl_as_n (ctrl_as_n),
    .adv_n     (adv_n),
    .act       (act)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .addr_in (addr_in),
    .base    (base)
  );

  burst_step_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .beat  (beat)
  );

  burst_order #(.CNT_W(CNT_W)) u_ord (
    .start_lo  (base[CNT_W-1:0]),
    .beat      (beat),
    .order_xor (order_xor),
    .lo        (lo)
  );

  generate
    if (UP_W > 0) begin : g_up
      assign addr_out = {base[ADDR_W-1:CNT_W], lo};
    end else begin : g_lo_only
      assign addr_out = lo;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              proc_as_n,
  input logic              ctrl_as_n,
  input logic              adv_n,
  input logic              order_xor,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_as_n || !ctrl_as_n) |=> addr_out == $past(addr_in)); // R4

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_as_n && ctrl_as_n) |=> addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_as_n && ctrl_as_n && adv_n)
      |=> (order_xor != $past(order_xor) || addr_out == $past(addr_out))); // R9

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_as_n && ctrl_as_n && !adv_n && !order_xor)
      |=> (order_xor || addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + ONE)); // R6

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> addr_out == '0); // R1
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .proc_as_n (proc_as_n),
  .ctrl_as_n (ctrl_as_n),
  .adv_n     (adv_n),
  .order_xor (order_xor),
  .addr_in   (addr_in),
  .addr_out  (addr_out)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_as_n = 1'b1;
  logic          ctrl_as_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_xor = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_run = 0;
  int n_fail = 0;
  int m_base = 0;
  int m_beat = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_as_n(proc_as_n), .ctrl_as_n(ctrl_as_n),
    .adv_n(adv_n), .order_xor(order_xor), .addr_in(addr_in), .addr_out(addr_out)
  );

  function automatic int model_addr();
    int lo;
    if (order_xor) lo = (m_base & 3) ^ m_beat;
    else           lo = ((m_base & 3) + m_beat) & 3;
    return (m_base & ~3) | lo;
  endfunction

  task automatic check(string req, int exp);
    n_run++;
    if (int'(addr_out) != exp) begin
      n_fail++;
      $display("FAIL %s: addr_out=%05h expected=%05h", req, addr_out, exp[AW-1:0]);
    end
  endtask

  // drive on falling edge, update model at rising edge, compare 1 ns later
  task automatic step(string req, bit p, bit c, bit a, bit m, int addr);
    @(negedge clk);
    proc_as_n = p; ctrl_as_n = c; adv_n = a; order_xor = m; addr_in = addr[AW-1:0];
    @(posedge clk);
    if (!rst_n) begin m_base = 0; m_beat = 0; end
    else if (!p || !c) begin m_base = addr & ((1 << AW) - 1); m_beat = 0; end
    else if (!a) m_beat = (m_beat + 1) & 3;
    #1;
    check(req, model_addr());
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step("R1 reset", 1, 1, 1, 0, 0);
    step("R1 reset held", 0, 1, 0, 0, 'h3FFFF);
    rst_n = 1'b1;
    // R2 processor strobe, linear walk from low bits 2
    step("R2 proc load", 0, 1, 1, 0, 'h2A5C6);
    for (int i = 0; i < 3; i++) step("R5 R6 linear advance", 1, 1, 0, 0, 'h11111);
    step("R8 linear wrap to start", 1, 1, 0, 0, 'h0);
    // R3 controller strobe, interleaved walk from low bits 1
    step("R3 ctrl load", 1, 0, 1, 1, 'h1F0F1);
    for (int i = 0; i < 3; i++) step("R7 interleaved advance", 1, 1, 0, 1, 'h2AAAA);
    step("R8 interleaved wrap to start", 1, 1, 0, 1, 'h0);
    // R4 strobe and advance together
    step("R4 strobe beats advance", 0, 1, 0, 0, 'h00003);
    step("R4 ctrl beats advance", 1, 0, 0, 0, 'h10003);
    step("R8 no carry into upper bits", 1, 1, 0, 0, 'h0);
    // R9 hold
    for (int i = 0; i < 3; i++) step("R9 hold", 1, 1, 1, 0, 'h3FFFF);
    // R10 order change between edges: beat 1 from start 3 -> linear 0, xor 2
    @(negedge clk);
    order_xor = 1'b1;
    #1;
    check("R10 order switch no latency", model_addr());
    n_run++;
    if (addr_out[1:0] != 2'd2) begin
      n_fail++;
      $display("FAIL R10: low=%0d expected=2", addr_out[1:0]);
    end
    step("R10 beat unchanged after switch", 1, 1, 1, 1, 'h0);
    // mixed stimulus
    for (int i = 0; i < 300; i++) begin
      int r = int'($urandom);
      step("R5 R6 R7 mixed", (r % 7) != 0, (r % 11) != 0, r[4], r[5], int'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule